// File: doc/BRIEF.md
# Conversion Clock Source Monitor

This block chooses the clock that paces a converter. It watches one pin that has two uses. When a clock toggles on the pin, the block selects that clock as the conversion clock. When the pin rests at a steady level, the block runs a free-running internal oscillator instead, and the level picks one of two rejection timings. The internal oscillator is modelled as an enable that pulses once every `INT_DIV` system clocks. All detection is digital: the pin passes through a synchronizer and a minimum-phase filter, and edges are counted in fixed watchdog windows of the system clock.

The selected clock leaves the block as a one-cycle enable, `conv_tick`. Switching between sources is break-before-make. The old source is gated off, a gap of `GAP` system clocks follows with no ticks, and then the new source is enabled. The surrounding converter holds `conv_busy` high while a conversion runs. If a source change overlaps that interval, the block marks the result of that conversion as suspect. The mark clears when the next conversion starts. All pins are plain control and status signals. No data stream crosses the boundary, so the block has no valid/ready handshake and no back-pressure.

Top module: `convclk_src_mon`

## Requirements
- R1: Once the pin is declared active, `ext_sel` is 1 and `int_osc_en` is 0. `conv_tick` then pulses once for each qualified rising edge of the pin, and `rej_mode` reads 2'b10 (external).
- R2: With the pin held static, `ext_sel` is 0 and `int_osc_en` is 1. `rej_mode` reads 2'b00 (60 Hz timing) for a static low and 2'b01 (50 Hz timing) for a static high.
- R3: When edges stop, a window of `WINDOW` cycles that contains no edge declares the pin static. The block returns to the internal oscillator no later than about two windows plus the gap after the last edge.
- R4: A pin phase (high or low) that lasts fewer than `MIN_PHASE` system clocks is ignored. Such pulses count as no edge and do not change `rej_mode`.
- R5: A source change while `conv_busy` is 0 leaves `result_suspect` unchanged, and ticks from the new source follow once the gap ends.
- R6: A source change that overlaps a period with `conv_busy` at 1 sets `result_suspect`. The flag holds until the next rising edge of `conv_busy` that has no switch in progress. If a conversion starts while a switch is in progress, the set takes priority over the clear.
- R7: While `switching` is 1, `conv_tick` stays 0 and neither source is enabled. `ext_sel` changes only at the end of a gap.
- R8: The pin is declared active only after two consecutive windows that each contain an edge. Within one window of the first toggle, `ext_sel` is still 0.
- R9: In internal mode, `conv_tick` pulses exactly once every `INT_DIV` system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fsel_pin | input | 1 | Asynchronous pin: a static level or an external clock |
| conv_busy | input | 1 | High while a conversion is in progress |
| conv_tick | output | 1 | One-cycle enable from the selected conversion clock |
| ext_sel | output | 1 | 1 when the external clock is the selected source |
| int_osc_en | output | 1 | 1 when the internal oscillator is enabled |
| switching | output | 1 | 1 during the break-before-make gap |
| rej_mode | output | 2 | 00 = 60 Hz, 01 = 50 Hz, 10 = external |
| result_suspect | output | 1 | The current or last conversion saw a source change |

## Verification
Two events can land in the same cycle: the start of a conversion, which clears the suspect flag, and a source switch in progress, which sets it. The bench provokes this on purpose. It starts the pin toggling with `conv_busy` low, polls `switching`, and raises `conv_busy` while the gap is still open. It then requires `result_suspect` to read 1 after the gap, since the set must win. A second directed case raises `conv_busy` with a stable source and requires the flag to clear. That shows the clear still works when nothing competes with it.

// File: rtl/cdet_pkg.sv
package cdet_pkg;
  typedef enum logic [1:0] {
    REJ_60  = 2'b00,
    REJ_50  = 2'b01,
    REJ_EXT = 2'b10
  } rej_e;
endpackage

// File: rtl/cdet_pin_qual.sv
module cdet_pin_qual #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PHASE   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_raw,
  output logic lvl,
  output logic edge_p,
  output logic rise_p
);
  localparam int CW = $clog2(MIN_PHASE + 1);
  localparam logic [CW-1:0] LAST = CW'(MIN_PHASE - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sync_out;
  logic [CW-1:0]          cnt;
  logic                   lvl_d;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b0;
        else if (i == 0) sync_q[i] <= pin_raw;
        else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign sync_out = sync_q[SYNC_STAGES-1];

  // The qualified level follows only after MIN_PHASE cycles of disagreement.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl   <= 1'b0;
      lvl_d <= 1'b0;
      cnt   <= '0;
    end else begin
      lvl_d <= lvl;
      if (sync_out == lvl) begin
        cnt <= '0;
      end else if (cnt == LAST) begin
        lvl <= sync_out;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign edge_p = lvl ^ lvl_d;
  assign rise_p = lvl & ~lvl_d;

  // R4
  lvl_follows_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl != $past(lvl)) |-> (lvl == $past(sync_out)));
endmodule

// File: rtl/cdet_activity.sv
module cdet_activity #(
  parameter int WINDOW      = 64,
  parameter int ACT_WINDOWS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_p,
  output logic active
);
  localparam int WW = $clog2(WINDOW);
  localparam int SW = $clog2(ACT_WINDOWS + 1);
  localparam logic [WW-1:0] WLAST = WW'(WINDOW - 1);
  localparam logic [SW-1:0] SFULL = SW'(ACT_WINDOWS);

  logic [WW-1:0] win;
  logic [SW-1:0] streak;
  logic          seen;
  logic          wrap;

  assign wrap = (win == WLAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win    <= '0;
      seen   <= 1'b0;
      streak <= '0;
    end else begin
      win <= wrap ? '0 : win + 1'b1;
      if (wrap) begin
        seen <= 1'b0;
        if (seen || edge_p) streak <= (streak == SFULL) ? SFULL : streak + 1'b1;
        else                streak <= '0;
      end else if (edge_p) begin
        seen <= 1'b1;
      end
    end
  end

  assign active = (streak == SFULL);

  // R8
  act_only_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(wrap));
  // R3
  quiet_window_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wrap) && !$past(seen) && !$past(edge_p)) |-> !active);
endmodule

// File: rtl/cdet_src_switch.sv
module cdet_src_switch #(
  parameter int INT_DIV = 8,
  parameter int GAP     = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want_ext,
  input  logic ext_rise,
  output logic cur_ext,
  output logic sw,
  output logic int_en,
  output logic ext_en,
  output logic conv_tick
);
  localparam int GW = (GAP > 1) ? $clog2(GAP) : 1;
  localparam int DW = (INT_DIV > 1) ? $clog2(INT_DIV) : 1;
  localparam logic [GW-1:0] GLAST = GW'(GAP - 1);
  localparam logic [DW-1:0] DLAST = DW'(INT_DIV - 1);

  logic [GW-1:0] gcnt;
  logic [DW-1:0] div;
  logic          tgt;
  logic          div_tick;

  // Break before make: the old source goes off, then GAP idle cycles.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_ext <= 1'b0;
      sw      <= 1'b0;
      tgt     <= 1'b0;
      gcnt    <= '0;
    end else if (sw) begin
      if (gcnt == GLAST) begin
        cur_ext <= tgt;
        sw      <= 1'b0;
        gcnt    <= '0;
      end else begin
        gcnt <= gcnt + 1'b1;
      end
    end else if (want_ext != cur_ext) begin
      sw   <= 1'b1;
      tgt  <= want_ext;
      gcnt <= '0;
    end
  end

  assign int_en = ~cur_ext & ~sw;
  assign ext_en = cur_ext & ~sw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         div <= '0;
    else if (!int_en || div == DLAST)   div <= '0;
    else                                div <= div + 1'b1;
  end

  assign div_tick  = int_en & (div == DLAST);
  assign conv_tick = div_tick | (ext_en & ext_rise);

  // R7
  sel_steady_in_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sw) && sw) |-> $stable(cur_ext));
  // R7
  sel_moves_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_ext != $past(cur_ext)) |-> $past(sw));
endmodule

// File: rtl/cdet_suspect.sv
module cdet_suspect (
  input  logic clk,
  input  logic rst_n,
  input  logic conv_busy,
  input  logic sw,
  output logic suspect
);
  logic busy_q;
  logic start;

  assign start = conv_busy & ~busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      suspect <= 1'b0;
    end else begin
      busy_q <= conv_busy;
      if (conv_busy && sw) suspect <= 1'b1;
      else if (start)      suspect <= 1'b0;
    end
  end

  // R6
  clean_start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !sw) |=> !suspect);
  // R5
  idle_holds_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_busy |=> (suspect == $past(suspect)));
endmodule

// File: rtl/convclk_src_mon.sv
module convclk_src_mon #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PHASE   = 4,
  parameter int WINDOW      = 64,
  parameter int ACT_WINDOWS = 2,
  parameter int INT_DIV     = 8,
  parameter int GAP         = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fsel_pin,
  input  logic       conv_busy,
  output logic       conv_tick,
  output logic       ext_sel,
  output logic       int_osc_en,
  output logic       switching,
  output logic [1:0] rej_mode,
  output logic       result_suspect
);
  import cdet_pkg::*;

  logic lvl, edge_p, rise_p, active, ext_en;
  rej_e rej;

  cdet_pin_qual #(.SYNC_STAGES(SYNC_STAGES), .MIN_PHASE(MIN_PHASE)) u_qual (
    .clk(clk), .rst_n(rst_n), .pin_raw(fsel_pin),
    .lvl(lvl), .edge_p(edge_p), .rise_p(rise_p));

  cdet_activity #(.WINDOW(WINDOW), .ACT_WINDOWS(ACT_WINDOWS)) u_act (
    .clk(clk), .rst_n(rst_n), .edge_p(edge_p), .active(active));

  cdet_src_switch #(.INT_DIV(INT_DIV), .GAP(GAP)) u_sw (
    .clk(clk), .rst_n(rst_n), .want_ext(active), .ext_rise(rise_p),
    .cur_ext(ext_sel), .sw(switching), .int_en(int_osc_en),
    .ext_en(ext_en), .conv_tick(conv_tick));

  cdet_suspect u_susp (
    .clk(clk), .rst_n(rst_n), .conv_busy(conv_busy), .sw(switching),
    .suspect(result_suspect));

  always_comb begin
    if (ext_sel)  rej = REJ_EXT;
    else if (lvl) rej = REJ_50;
    else          rej = REJ_60;
  end
  assign rej_mode = rej;

  // R7
  no_tick_in_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    switching |-> !conv_tick);
  // R7
  one_source_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({int_osc_en, ext_en}));
endmodule

// File: tb/convclk_src_mon_tb.sv
module convclk_src_mon_tb_top;
  localparam int WINDOW  = 64;
  localparam int INT_DIV = 8;
  localparam int SETTLE  = 4*WINDOW + 40;

  logic clk = 1'b0, rst_n = 1'b0, pin = 1'b0, busy = 1'b0;
  logic conv_tick, ext_sel, int_osc_en, switching, result_suspect;
  logic [1:0] rej_mode;

  int checks = 0, failures = 0, gap_ticks = 0, cyc = 0;
  int pmode = 0;       // 0 static, 1 toggle, 2 static low with short glitches
  logic plvl = 1'b0;
  int half = 8;

  always #2 clk = ~clk;

  convclk_src_mon dut_i (
    .clk(clk), .rst_n(rst_n), .fsel_pin(pin), .conv_busy(busy),
    .conv_tick(conv_tick), .ext_sel(ext_sel), .int_osc_en(int_osc_en),
    .switching(switching), .rej_mode(rej_mode), .result_suspect(result_suspect));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_rej(input int m, input logic l);
    if (m == 1) return 2;
    if (m == 2) return 0;
    return l ? 1 : 0;
  endfunction

  task automatic count_ticks(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (conv_tick) c++;
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // pin driver
  initial begin
    forever begin
      @(negedge clk);
      case (pmode)
        1: begin pin = ~pin; repeat (half-1) @(negedge clk); end
        2: begin pin = 1'b0; repeat (20) @(negedge clk); pin = 1'b1;
                 repeat (2) @(negedge clk); pin = 1'b0; end
        default: pin = plvl;
      endcase
    end
  end

  // R7 monitor: no tick while the gap is open
  always @(negedge clk) begin
    cyc++;
    if (rst_n && switching && conv_tick) gap_ticks++;
  end

  initial begin
    int c, e, m, dummy;
    dummy = $urandom(32'h5eed);
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(2);
    chk(ext_sel == 0, "R2 reset ext_sel", ext_sel, 0);
    chk(int_osc_en == 1, "R2 reset int_osc_en", int_osc_en, 1);
    chk(rej_mode == 0, "R2 reset rej_mode", rej_mode, 0);
    chk(result_suspect == 0, "R6 reset suspect", result_suspect, 0);

    // R9 internal tick rate
    wait_cyc(10);
    count_ticks(8*INT_DIV, c);
    chk(c == 8, "R9 internal ticks", c, 8);

    // R2 static high -> 50 Hz timing
    plvl = 1'b1; wait_cyc(20);
    chk(rej_mode == 1, "R2 static high", rej_mode, 1);
    chk(ext_sel == 0, "R2 static high internal", ext_sel, 0);

    // R4 short glitches ignored
    pmode = 2; wait_cyc(SETTLE);
    chk(rej_mode == 0, "R4 glitch rej", rej_mode, 0);
    chk(ext_sel == 0, "R4 glitch ext_sel", ext_sel, 0);
    count_ticks(8*INT_DIV, c);
    chk(c == 8, "R4 glitch ticks", c, 8);

    // R8 activation delay, R1 external, R6 flagging
    busy = 1'b1; wait_cyc(3);
    half = 10; pmode = 1;
    wait_cyc(WINDOW - 2);
    chk(ext_sel == 0, "R8 not active within one window", ext_sel, 0);
    wait_cyc(SETTLE);
    chk(ext_sel == 1, "R1 ext_sel", ext_sel, 1);
    chk(int_osc_en == 0, "R1 int_osc_en off", int_osc_en, 0);
    chk(rej_mode == 2, "R1 rej ext", rej_mode, 2);
    count_ticks(256, c);
    e = 256 / (2*half);
    chk(c >= e-1 && c <= e+1, "R1 ext ticks", c, e);
    busy = 1'b0; wait_cyc(2);
    chk(result_suspect == 1, "R6 change in conversion flagged", result_suspect, 1);
    busy = 1'b1; wait_cyc(5);
    chk(result_suspect == 0, "R6 next conversion clean", result_suspect, 0);
    busy = 1'b0; wait_cyc(2);

    // R3 fallback, R5 change during idle
    plvl = 1'b1; pmode = 0;
    wait_cyc(2*WINDOW + 40);
    chk(ext_sel == 0, "R3 fallback", ext_sel, 0);
    chk(rej_mode == 1, "R3 fallback rej", rej_mode, 1);
    chk(result_suspect == 0, "R5 idle switch no flag", result_suspect, 0);
    count_ticks(8*INT_DIV, c);
    chk(c == 8, "R5 ticks resume", c, 8);

    // R6 coincidence: conversion starts while a switch is in progress
    half = 7; pmode = 1;
    @(negedge clk);
    for (int i = 0; i < 8*WINDOW && !switching; i++) @(negedge clk);
    chk(switching == 1, "R6 gap reached", switching, 1);
    busy = 1'b1;
    wait_cyc(10);
    chk(result_suspect == 1, "R6 set wins over start", result_suspect, 1);
    busy = 1'b0; wait_cyc(2);

    // random patterns
    for (int k = 0; k < 10; k++) begin
      m = $urandom % 3;
      plvl = ($urandom % 2) == 1;
      half = 6 + ($urandom % 11);
      pmode = m;
      wait_cyc(SETTLE);
      e = exp_rej(m, plvl);
      chk(rej_mode == e, (m == 1) ? "R1 random rej" : "R2 random rej", rej_mode, e);
      chk(ext_sel == (m == 1), "R3 random source", ext_sel, (m == 1));
      if (m != 1) begin
        count_ticks(8*INT_DIV, c);
        chk(c == 8, "R9 random ticks", c, 8);
      end
    end

    chk(gap_ticks == 0, "R7 no tick in gap", gap_ticks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // watchdog
  initial begin
    wait (cyc >= 150000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule